// File: doc/BRIEF.md
# Sticky Event Interrupt Register Unit

This block collects single-cycle event pulses from a serial bus master engine and turns them into one level-sensitive interrupt request. Each pulse sets a sticky bit in a status register. Software clears a status bit by writing a one to it, so writing back a value it has just read clears exactly the events it has seen.

A mask decides which status bits can reach the interrupt line. Software never writes the mask directly. It sets mask bits through a write-only disable register and clears them through a write-only enable register. The mask can be read at its own offset.

All of these views use one bit layout:

| Bit | Event |
|-----|-------|
| 0 | transfer done |
| 1 | data level |
| 2 | no acknowledge |
| 3 | timeout |
| 4 | target ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 9 | arbitration lost |

Bit 8 and bits 10 and up are not defined.

The block also contains the small register decode that serves these offsets on a simple write-strobe bus with a combinational read path.

Top module: `bus_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0, the mask reads 0x2FF (every defined source masked) and `irq` is low.
- R2: A one on a defined bit of `evt` sets that status bit at the next clock edge. The bit then stays set until it is cleared by a write.
- R3: A write to offset 0x10 clears every status bit whose `wdata` bit is one. Status bits whose `wdata` bit is zero keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x24 clears each mask bit whose `wdata` bit is one and leaves the other mask bits unchanged.
- R6: A write to offset 0x28 sets each defined mask bit whose `wdata` bit is one and leaves the other mask bits unchanged. Writing 0x2FF masks every source.
- R7: `irq` is high exactly while at least one status bit is set whose mask bit is clear.
- R8: Bit 8 and bits 10 to 31 always read 0 in status and mask, and a pulse on `evt` bit 8 has no effect.
- R9: The mask reads at offset 0x20. Reads of 0x24, 0x28 and any unmapped offset return 0. Writes to 0x20 or to an unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| evt | input | 10 | Event pulses in the shared bit layout |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a clearing write to status that lands in the same cycle as a new event on the same bit. In that case the event must survive. Directed steps drive the pulse and the write-one-to-clear together on several bits at once, including bits that have no event pending. The random phase also issues writes with a frequent event vector, so collisions recur under many different mask states. After every step, the status, the mask and `irq` are compared against the bench model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SRC_W  = 10;

  localparam int B_DONE    = 0;
  localparam int B_LEVEL   = 1;
  localparam int B_NOACK   = 2;
  localparam int B_TIMEOUT = 3;
  localparam int B_TREADY  = 4;
  localparam int B_RX_OVF  = 5;
  localparam int B_TX_OVF  = 6;
  localparam int B_RX_UNF  = 7;
  localparam int B_ARBLOST = 9;

  localparam logic [SRC_W-1:0] SRC_DEFINED =
    SRC_W'((1 << B_DONE) | (1 << B_LEVEL) | (1 << B_NOACK) | (1 << B_TIMEOUT) |
           (1 << B_TREADY) | (1 << B_RX_OVF) | (1 << B_TX_OVF) |
           (1 << B_RX_UNF) | (1 << B_ARBLOST));

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DISABLE = 8'h28;

  // Next value of one sticky bit: a new event beats a clearing write.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

  // Next value of one mask bit from the two write-only views.
  function automatic logic mask_next(input logic cur, input logic unmask, input logic domask);
    return (cur & ~unmask) | domask;
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_W-1:0]  stat_q,
  input  logic [SRC_W-1:0]  mask_q,
  output logic [SRC_W-1:0]  clr_vec,
  output logic [SRC_W-1:0]  en_vec,
  output logic [SRC_W-1:0]  dis_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - SRC_W;

  logic hit_stat, hit_en, hit_dis;
  logic [SRC_W-1:0] wsrc;

  assign hit_stat = wr_en && (addr == OFS_STATUS);
  assign hit_en   = wr_en && (addr == OFS_ENABLE);
  assign hit_dis  = wr_en && (addr == OFS_DISABLE);
  assign wsrc     = wdata[SRC_W-1:0] & SRC_DEFINED;

  assign clr_vec = hit_stat ? wsrc : '0;
  assign en_vec  = hit_en   ? wsrc : '0;
  assign dis_vec = hit_dis  ? wsrc : '0;

  always_comb begin
    unique case (addr)
      OFS_STATUS: rdata = {{PAD_W{1'b0}}, stat_q & SRC_DEFINED};
      OFS_MASK:   rdata = {{PAD_W{1'b0}}, mask_q & SRC_DEFINED};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt,
  input  logic [SRC_W-1:0] clr_vec,
  output logic [SRC_W-1:0] stat_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (SRC_DEFINED[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= sticky_next(stat_q[i], clr_vec[i], evt[i]);
      end
    end else begin : g_tie
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] en_vec,
  input  logic [SRC_W-1:0] dis_vec,
  output logic [SRC_W-1:0] mask_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (SRC_DEFINED[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) mask_q[i] <= 1'b1;
        else        mask_q[i] <= mask_next(mask_q[i], en_vec[i], dis_vec[i]);
      end
    end else begin : g_tie
      assign mask_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bus_irq_ctrl.sv
module bus_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [9:0]        evt,
  output logic              irq
);
  logic [SRC_W-1:0] stat_q, mask_q;
  logic [SRC_W-1:0] clr_vec, en_vec, dis_vec;
  logic [SRC_W-1:0] live_src;

  irq_reg_decode u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat_q(stat_q), .mask_q(mask_q),
    .clr_vec(clr_vec), .en_vec(en_vec), .dis_vec(dis_vec),
    .rdata(rdata)
  );

  irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_vec(clr_vec), .stat_q(stat_q)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .dis_vec(dis_vec), .mask_q(mask_q)
  );

  assign live_src = stat_q & ~mask_q;
  assign irq      = |live_src;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] evt,
  input logic [SRC_W-1:0] clr_vec,
  input logic [SRC_W-1:0] en_vec,
  input logic [SRC_W-1:0] dis_vec,
  input logic [SRC_W-1:0] stat_q,
  input logic [SRC_W-1:0] mask_q,
  input logic             irq
);
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & SRC_DEFINED) != '0) |=>
      ((stat_q & $past(evt & SRC_DEFINED)) == $past(evt & SRC_DEFINED)));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((stat_q & $past(clr_vec & ~evt)) == '0));

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & evt) != '0) |=> ((stat_q & $past(clr_vec & evt)) == $past(clr_vec & evt)));

  a_r5_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec != '0) |=> ((mask_q & $past(en_vec)) == '0));

  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_vec != '0) |=> ((mask_q & $past(dis_vec)) == $past(dis_vec)));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == SRC_DEFINED) |-> !irq);

  a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~SRC_DEFINED) == '0) && ((mask_q & ~SRC_DEFINED) == '0));
endmodule

bind bus_irq_ctrl irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt(evt), .clr_vec(clr_vec), .en_vec(en_vec),
  .dis_vec(dis_vec), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/bus_irq_ctrl_tb_top.sv
module bus_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] DEF = 10'h2FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [9:0] m_stat, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .irq(irq)
  );

  function automatic logic [9:0] exp_stat(input logic [9:0] s, input bit w,
      input logic [7:0] a, input logic [31:0] d, input logic [9:0] e);
    logic [9:0] clr = (w && a == 8'h10) ? d[9:0] : 10'h0;
    return ((s & ~clr) | e) & DEF;
  endfunction

  function automatic logic [9:0] exp_mask(input logic [9:0] m, input bit w,
      input logic [7:0] a, input logic [31:0] d);
    logic [9:0] r = m;
    if (w && a == 8'h24) r = r & ~d[9:0];
    if (w && a == 8'h28) r = r | d[9:0];
    return r & DEF;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d, input logic [9:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    m_stat = exp_stat(m_stat, w, a, d, e);
    m_mask = exp_mask(m_mask, w, a, d);
    #1;
    wr_en = 1'b0; evt = '0;
    check("R7 irq", {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    wr_en = 1'b0; evt = '0; addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    m_stat = '0; m_mask = DEF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd("R1 status", 8'h10, 32'h0);
    rd("R1 mask", 8'h20, 32'h2FF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R2 sticky while masked
    step(0, 8'h00, 0, 10'h005);
    step(0, 8'h00, 0, 10'h000);
    rd("R2 status sticky", 8'h10, 32'h005);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    // R5 unmask bit 2 only
    step(1, 8'h24, 32'h4, 0);
    rd("R5 mask", 8'h20, 32'h2FB);
    check("R7 irq unmasked", {31'b0, irq}, 32'h1);
    // R9 write-only views and unmapped reads
    rd("R9 enable reads zero", 8'h24, 32'h0);
    rd("R9 disable reads zero", 8'h28, 32'h0);
    rd("R9 unmapped reads zero", 8'h14, 32'h0);
    step(1, 8'h20, 32'hFFFF_FFFF, 0);
    step(1, 8'h1C, 32'hFFFF_FFFF, 0);
    rd("R9 mask write ignored", 8'h20, 32'h2FB);
    rd("R9 status untouched", 8'h10, 32'h005);
    // R3 partial clear
    step(1, 8'h10, 32'h4, 0);
    rd("R3 clear bit2", 8'h10, 32'h001);
    check("R3 irq drops", {31'b0, irq}, 32'h0);
    // R4 collision
    step(0, 8'h00, 0, 10'h240);
    step(1, 8'h10, 32'hFFFF_FFFF, 10'h202);
    rd("R4 event wins", 8'h10, 32'h202);
    // R8 undefined bits and bit 8 event
    step(0, 8'h00, 0, 10'h100);
    rd("R8 bit8 event ignored", 8'h10, 32'h202);
    step(1, 8'h24, 32'hFFFF_FFFF, 0);
    rd("R8 mask undefined zero", 8'h20, 32'h0);
    check("R7 irq all open", {31'b0, irq}, 32'h1);
    // R6 mask all
    step(1, 8'h28, 32'h2FF, 0);
    rd("R6 all masked", 8'h20, 32'h2FF);
    check("R6 irq off", {31'b0, irq}, 32'h0);
    step(1, 8'h24, 32'h3FF, 0);
    step(1, 8'h28, 32'h0A0, 0);
    rd("R6 partial disable", 8'h20, 32'h0A0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [9:0] e;
      case ($urandom % 6)
        0: a = 8'h10; 1: a = 8'h24; 2: a = 8'h28;
        3: a = 8'h20; 4: a = 8'h18; default: a = 8'h10;
      endcase
      d = $urandom;
      e = (($urandom % 3) == 0) ? 10'($urandom) : 10'h0;
      step(($urandom % 4) != 0, a, d, e);
      rd("R2 R3 R4 random status", 8'h10, {22'b0, m_stat});
      rd("R5 R6 random mask", 8'h20, {22'b0, m_mask});
    end
    finish_run();
  end
endmodule